// File: doc/BRIEF.md
# Instruction Address Sequencer with One-Level Return Stack

This block keeps the instruction address of a small microcontroller core. The address is 11 bits wide. Each cycle the core's decoder may report one of several events. An executed instruction advances the address by its byte length. A taken jump loads an operand target. A subroutine call saves the address of the following instruction and then loads the target. A return restores the saved address.

Only one return address can be held. It sits in a single register, and a 1-bit depth flag tracks whether that register is occupied. Two cases are errors: a call while the flag is already set, or a return while it is clear. On either error the block clears the address and the flag and raises a one-cycle system reset request. While that request is high, every strobe is ignored.

The low byte of the return register also appears as an ordinary data-memory byte, which the core can read and write. A write through this byte replaces the upper three bits of the register with a fixed fill pattern. The return register is not cleared by reset.

Top module: `pc_seq`

## Requirements
- R1: While `rst` is high at a rising edge, after that edge `pc` = 0x000, `sp` = 0 and `rst_req` = 0.
- R2: With `adv` high and no `ret`, `call` or `jmp`, the next `pc` is (`pc` + `ilen`) mod 2048. An `ilen` of 0 leaves `pc` unchanged.
- R3: With `jmp` high and no `ret` or `call`, the next `pc` equals `target`, and `adv` has no effect.
- R4: A call (`call` high, `ret` low, `sp` = 0) sets `sp` to 1, loads `pc` from `target`, and stores `pc` + `ilen` (mod 2048) into the return register.
- R5: A return (`ret` high, `sp` = 1) clears `sp` and loads `pc` from the return register. The return register keeps its value.
- R6: A call with `sp` = 1, or a return with `sp` = 0, makes the next `pc` 0x000 and `sp` 0. It leaves the return register unchanged and holds `rst_req` high for exactly the one following cycle.
- R7: During the cycle `rst_req` is high, all strobes are ignored and `pc` stays at 0x000.
- R8: When several strobes are high together, the priority is return, then call, then jump, then advance.
- R9: `dm_rdata` always shows bits 7:0 of the return register.
- R10: A data write (`dm_sel` and `dm_we` high) loads bits 7:0 of the return register with `dm_wdata` and bits 10:8 with `HI_FILL` (default 3'b111). The next return loads that combined value.
- R11: Reset leaves the return register unchanged.
- R12: `sp` changes only through a call, a return or a stack error. Jumps, advances and data writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| adv | input | 1 | Instruction executed, advance by `ilen` |
| ilen | input | 2 | Byte length of the executed instruction |
| jmp | input | 1 | Taken jump strobe |
| call | input | 1 | Subroutine call strobe |
| ret | input | 1 | Return strobe |
| target | input | 11 | Jump or call destination from the operand |
| dm_sel | input | 1 | Data access addresses the aliased byte |
| dm_we | input | 1 | Data write enable |
| dm_wdata | input | 8 | Data write value |
| dm_rdata | output | 8 | Low byte of the return register |
| pc | output | 11 | Current instruction address |
| sp | output | 1 | Return register occupied |
| rst_req | output | 1 | One-cycle system reset request on stack error |

## Verification
A wrong depth flag shows up on the second stack event. A healthy call/return pair then ends in a spurious `rst_req` with `pc` at zero, or a nesting error fails to raise one, and either shows one edge after the strobe. A corrupted return register shows at once on `dm_rdata` for its low byte. Its upper bits show only when the next return loads `pc`. The priority and advance arithmetic show in `pc` one edge after the strobes.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_INC   = 3'd1,
        OP_JMP   = 3'd2,
        OP_CALL  = 3'd3,
        OP_RET   = 3'd4,
        OP_FAULT = 3'd5
    } seq_op_e;

    typedef struct packed {
        logic adv;
        logic jmp;
        logic call;
        logic ret;
    } seq_req_t;

    // Priority: blocked cycle, stack error, return, call, jump, advance.
    function automatic seq_op_e pick_op(input logic blocked,
                                        input logic depth,
                                        input seq_req_t r);
        seq_op_e op;
        if (blocked)
            op = OP_HOLD;
        else if (r.ret)
            op = depth ? OP_RET : OP_FAULT;
        else if (r.call)
            op = depth ? OP_FAULT : OP_CALL;
        else if (r.jmp)
            op = OP_JMP;
        else if (r.adv)
            op = OP_INC;
        else
            op = OP_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/pc_seq_decode.sv
module pc_seq_decode
    import pc_seq_pkg::*;
(
    input  logic     blocked,
    input  logic     depth,
    input  seq_req_t req,
    output seq_op_e  op
);
    always_comb op = pick_op(blocked, depth, req);
endmodule

// File: rtl/pc_seq_counter.sv
module pc_seq_counter
    import pc_seq_pkg::*;
#(
    parameter int AW = 11,
    parameter int LW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_op_e       op,
    input  logic [LW-1:0] ilen,
    input  logic [AW-1:0] target,
    input  logic [AW-1:0] ras,
    output logic [AW-1:0] pc_q,
    output logic [AW-1:0] pc_plus
);
    logic [AW-1:0] pc_d;

    always_comb pc_plus = pc_q + AW'(ilen);

    always_comb begin
        unique case (op)
            OP_INC:           pc_d = pc_plus;
            OP_JMP, OP_CALL:  pc_d = target;
            OP_RET:           pc_d = ras;
            OP_FAULT:         pc_d = '0;
            default:          pc_d = pc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end
endmodule

// File: rtl/pc_seq_stack.sv
module pc_seq_stack
    import pc_seq_pkg::*;
#(
    parameter int AW = 11,
    parameter int DW = 8,
    parameter logic [AW-DW-1:0] HI_FILL = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_op_e       op,
    input  logic [AW-1:0] save_val,
    input  logic          alias_wr,
    input  logic [DW-1:0] alias_wdata,
    output logic          depth_q,
    output logic          fault_q,
    output logic [AW-1:0] ras_q
);
    // Depth flag and one-cycle reset request.
    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            fault_q <= (op == OP_FAULT);
            unique case (op)
                OP_CALL:          depth_q <= 1'b1;
                OP_RET, OP_FAULT: depth_q <= 1'b0;
                default:          depth_q <= depth_q;
            endcase
        end
    end

    // Return register: outside reset on purpose.
    always_ff @(posedge clk) begin
        if (op == OP_CALL)
            ras_q <= save_val;
        else if (alias_wr)
            ras_q <= {HI_FILL, alias_wdata};
    end
endmodule

// File: rtl/pc_seq.sv
module pc_seq
    import pc_seq_pkg::*;
#(
    parameter int AW = 11,
    parameter int LW = 2,
    parameter int DW = 8,
    parameter logic [AW-DW-1:0] HI_FILL = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic [LW-1:0] ilen,
    input  logic          jmp,
    input  logic          call,
    input  logic          ret,
    input  logic [AW-1:0] target,
    input  logic          dm_sel,
    input  logic          dm_we,
    input  logic [DW-1:0] dm_wdata,
    output logic [DW-1:0] dm_rdata,
    output logic [AW-1:0] pc,
    output logic          sp,
    output logic          rst_req
);
    seq_req_t      req;
    seq_op_e       op;
    logic [AW-1:0] pc_plus;
    logic [AW-1:0] ras_q;
    logic          depth_q;
    logic          fault_q;

    always_comb begin
        req.adv  = adv;
        req.jmp  = jmp;
        req.call = call;
        req.ret  = ret;
    end

    pc_seq_decode u_dec (
        .blocked (fault_q),
        .depth   (depth_q),
        .req     (req),
        .op      (op)
    );

    pc_seq_counter #(.AW(AW), .LW(LW)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .ilen    (ilen),
        .target  (target),
        .ras     (ras_q),
        .pc_q    (pc),
        .pc_plus (pc_plus)
    );

    pc_seq_stack #(.AW(AW), .DW(DW), .HI_FILL(HI_FILL)) u_stk (
        .clk         (clk),
        .rst         (rst),
        .op          (op),
        .save_val    (pc_plus),
        .alias_wr    (dm_sel & dm_we),
        .alias_wdata (dm_wdata),
        .depth_q     (depth_q),
        .fault_q     (fault_q),
        .ras_q       (ras_q)
    );

    always_comb begin
        sp       = depth_q;
        rst_req  = fault_q;
        dm_rdata = ras_q[DW-1:0];
    end
endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk #(
    parameter int AW = 11,
    parameter int LW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          adv,
    input logic [LW-1:0] ilen,
    input logic          jmp,
    input logic          call,
    input logic          ret,
    input logic [AW-1:0] target,
    input logic [AW-1:0] ras,
    input logic [AW-1:0] pc,
    input logic          sp,
    input logic          rst_req
);
    logic err;
    always_comb err = (ret && !sp) || (call && !ret && sp);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (pc == '0 && !sp && !rst_req));                                    // R1
    AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (!rst_req && adv && !jmp && !call && !ret) |=> pc == AW'($past(pc) + AW'($past(ilen)))); // R2
    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!rst_req && jmp && !call && !ret) |=> pc == $past(target));               // R3
    AST_CALL_PUSH: assert property (@(posedge clk) disable iff (rst)
        (!rst_req && call && !ret && !sp) |=> (sp && pc == $past(target)
            && ras == AW'($past(pc) + AW'($past(ilen)))));                          // R4
    AST_RET_POP: assert property (@(posedge clk) disable iff (rst)
        (!rst_req && ret && sp) |=> (!sp && pc == $past(ras) && $stable(ras)));    // R5
    AST_STACK_ERROR: assert property (@(posedge clk) disable iff (rst)
        (!rst_req && err) |=> (rst_req && pc == '0 && !sp));                       // R6
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);                                                     // R6
    AST_BLOCKED_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> (pc == '0 && !sp));                                            // R7
    AST_SP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!call && !ret) |=> $stable(sp));                                          // R12
endmodule

bind pc_seq pc_seq_chk #(.AW(AW), .LW(LW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .ilen    (ilen),
    .jmp     (jmp),
    .call    (call),
    .ret     (ret),
    .target  (target),
    .ras     (ras_q),
    .pc      (pc),
    .sp      (sp),
    .rst_req (rst_req)
);

// File: tb/sim_pc_seq.sv
module sim_pc_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adv = 1'b0;
    logic [1:0]  ilen = '0;
    logic        jmp = 1'b0, call = 1'b0, ret = 1'b0;
    logic [10:0] target = '0;
    logic        dm_sel = 1'b0, dm_we = 1'b0;
    logic [7:0]  dm_wdata = '0;
    logic [7:0]  dm_rdata;
    logic [10:0] pc;
    logic        sp, rst_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pc_seq u0 (
        .clk(clk), .rst(rst), .adv(adv), .ilen(ilen), .jmp(jmp), .call(call),
        .ret(ret), .target(target), .dm_sel(dm_sel), .dm_we(dm_we),
        .dm_wdata(dm_wdata), .dm_rdata(dm_rdata), .pc(pc), .sp(sp),
        .rst_req(rst_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Drive one cycle's inputs, let one rising edge pass, sample at the next falling edge.
    task automatic cyc(input bit a, input int l, input bit j, input bit c, input bit r,
                       input int t, input bit ds, input bit dw, input int wd);
        adv = a; ilen = 2'(l); jmp = j; call = c; ret = r; target = 11'(t);
        dm_sel = ds; dm_we = dw; dm_wdata = 8'(wd);
        @(negedge clk);
        adv = 0; ilen = '0; jmp = 0; call = 0; ret = 0; target = '0;
        dm_sel = 0; dm_we = 0; dm_wdata = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int exp_pc;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        chk("R1 pc", pc, 0); chk("R1 sp", sp, 0); chk("R1 rst_req", rst_req, 0);

        // R3 and R2: sweep every target, then advance by a varying length.
        for (int t = 0; t < 2048; t++) begin
            cyc(1, 3, 1, 0, 0, t, 0, 0, 0);
            chk("R3 jump", pc, t);
            cyc(1, t % 4, 0, 0, 0, 0, 0, 0, 0);
            chk("R2 advance", pc, (t + t % 4) & 11'h7FF);
        end
        chk("R12 sp after sweep", sp, 0);

        // R4/R5/R9: call and return sweep over lengths and addresses.
        for (int k = 0; k < 256; k++) begin
            int base = (k * 37 + 2040) & 11'h7FF;
            int l = k % 4;
            int ret_to = (base + l) & 11'h7FF;
            cyc(0, 0, 1, 0, 0, base, 0, 0, 0);
            cyc(0, l, 0, 1, 0, (k * 11) & 11'h7FF, 0, 0, 0);
            chk("R4 target", pc, (k * 11) & 11'h7FF);
            chk("R4 sp", sp, 1);
            chk("R9 low byte", dm_rdata, ret_to & 8'hFF);
            cyc(0, 0, 0, 0, 1, 0, 0, 0, 0);
            chk("R5 pc", pc, ret_to);
            chk("R5 sp", sp, 0);
            chk("R5 ras kept", dm_rdata, ret_to & 8'hFF);
        end

        // R6/R7: underflow, then blocked cycle.
        cyc(0, 0, 1, 0, 0, 11'h123, 0, 0, 0);
        cyc(0, 2, 0, 1, 0, 11'h456, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0);
        chk("R5 pc 0x125", pc, 11'h125);
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0);
        chk("R6 underflow pc", pc, 0); chk("R6 underflow req", rst_req, 1);
        chk("R6 ras unchanged", dm_rdata, 8'h25);
        cyc(1, 3, 1, 1, 0, 11'h77, 0, 0, 0);
        chk("R7 blocked pc", pc, 0); chk("R7 blocked sp", sp, 0);
        chk("R6 req one cycle", rst_req, 0);

        // R6: overflow.
        cyc(0, 1, 0, 1, 0, 11'h010, 0, 0, 0);
        chk("R4 sp set", sp, 1);
        cyc(0, 3, 0, 1, 0, 11'h300, 0, 0, 0);
        chk("R6 overflow pc", pc, 0); chk("R6 overflow sp", sp, 0);
        chk("R6 overflow req", rst_req, 1);
        chk("R6 ras kept", dm_rdata, 8'h01);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R6 req cleared", rst_req, 0);

        // R8: priority.
        cyc(0, 0, 1, 0, 0, 11'h200, 0, 0, 0);
        cyc(1, 2, 1, 0, 0, 11'h050, 0, 0, 0);
        chk("R8 jump over advance", pc, 11'h050);
        cyc(1, 3, 1, 1, 0, 11'h0A0, 0, 0, 0);
        chk("R8 call over jump pc", pc, 11'h0A0); chk("R8 call over jump sp", sp, 1);
        chk("R8 call saved", dm_rdata, 8'h53);
        cyc(1, 1, 1, 1, 1, 11'h3FF, 0, 0, 0);
        chk("R8 return over call pc", pc, 11'h053); chk("R8 return over call sp", sp, 0);
        cyc(0, 0, 0, 1, 1, 11'h3FF, 0, 0, 0);
        chk("R8 return wins underflow", rst_req, 1);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);

        // R10/R12: alias write while occupied, then return.
        cyc(0, 0, 1, 0, 0, 11'h100, 0, 0, 0);
        cyc(0, 1, 0, 1, 0, 11'h200, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 1, 8'h3C);
        chk("R10 write low byte", dm_rdata, 8'h3C);
        chk("R12 sp after data write", sp, 1);
        cyc(1, 2, 0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 11'h111, 0, 0, 0);
        chk("R12 sp after jump/advance", sp, 1);
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 8'hEE);
        chk("R10 no write without we", dm_rdata, 8'h3C);
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0);
        chk("R10 fill on return", pc, 11'h73C);

        // R11: reset leaves the return register.
        cyc(0, 0, 0, 0, 0, 0, 1, 1, 8'h5A);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 pc after reset", pc, 0);
        chk("R11 ras survives reset", dm_rdata, 8'h5A);

        finish_run();
    end
endmodule